// File: doc/BRIEF.md
# Registered 32-bit integer ALU with direct funct decoding

This block is the integer arithmetic and logic unit for the register–register and register–immediate instruction groups of a 32-bit load/store core. The operation is chosen straight from the instruction's funct3 field, bit 30 of the instruction (called `funct7_b5` here), and a flag that marks the immediate form. It supports add, subtract, signed and unsigned set-less-than, AND, OR, XOR, and logical and arithmetic shifts.

Operand B is either the second source register or an immediate that has already been sign-extended upstream. The result is registered and appears one clock after the operands are presented. Overflow is neither detected nor reported.

Top module: `rv_int_alu`

## Requirements
- R1: In the register form with funct3 = 000, `funct7_b5` = 0 gives A + B and `funct7_b5` = 1 gives A − B. Both results wrap modulo 2^32 with no overflow indication.
- R2: In the immediate form (`imm_form` = 1) with funct3 = 000, the result is always A + B, whatever the value of `funct7_b5`.
- R3: funct3 = 010 writes 1 when A < B as two's-complement signed values and 0 otherwise. Bits 31:1 of the result are zero.
- R4: funct3 = 011 writes 1 when A < B as unsigned bit patterns and 0 otherwise. Bits 31:1 of the result are zero.
- R5: funct3 = 100 gives A XOR B, 110 gives A OR B, and 111 gives A AND B, bit by bit. When B is all ones, XOR returns the inverse of A.
- R6: funct3 = 001 shifts A left by B[4:0] and fills the vacated low bits with zeros. B[31:5] has no effect.
- R7: funct3 = 101 shifts A right by B[4:0]. With `funct7_b5` = 0 the vacated high bits are filled with zeros. With `funct7_b5` = 1 they are filled with A[31]. Both forms (`imm_form` 0 and 1) behave this way.
- R8: `result` holds 0 while `rst_n` is low. Outside reset, `result` shows the outcome for the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_a | input | 32 | Operand A (first source register) |
| opnd_b | input | 32 | Operand B (second source register or sign-extended immediate) |
| funct3 | input | 3 | Operation field of the instruction |
| funct7_b5 | input | 1 | Instruction bit 30: selects subtract or arithmetic shift |
| imm_form | input | 1 | 1 when the instruction is the immediate form |
| result | output | 32 | Registered result |

## Verification
The bench targets the corners where an ALU most often goes wrong.

- **Arithmetic wrap:** all-ones plus one, and the most negative value minus one. A design that widened or saturated would give a non-wrapped result.
- **Set-less-than signedness:** operand pairs where the signed and unsigned orderings disagree. A design that mixed up the two comparisons would return the inverted bit.
- **Shift amount masking:** shift amounts whose bits above bit 4 are set. A design that used the whole of B would shift everything out.
- **Arithmetic shift fill:** negative and positive A, in both forms. A design with the wrong fill would show zeros, or sign copies, in the high bits.
- **Immediate-form subtract:** an immediate-form add with bit 30 set. A design that did not suppress subtract would return a difference instead of a sum.

// File: rtl/alu_pkg.sv
package alu_pkg;
    parameter int unsigned ALU_XLEN = 32;

    typedef enum logic [3:0] {
        OP_ADD,
        OP_SUB,
        OP_SLT,
        OP_SLTU,
        OP_XOR,
        OP_OR,
        OP_AND,
        OP_SLL,
        OP_SRL,
        OP_SRA
    } alu_op_e;

    localparam logic [2:0] F3_ADDSUB = 3'b000;
    localparam logic [2:0] F3_SLL    = 3'b001;
    localparam logic [2:0] F3_SLT    = 3'b010;
    localparam logic [2:0] F3_SLTU   = 3'b011;
    localparam logic [2:0] F3_XOR    = 3'b100;
    localparam logic [2:0] F3_SHR    = 3'b101;
    localparam logic [2:0] F3_OR     = 3'b110;
    localparam logic [2:0] F3_AND    = 3'b111;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [2:0] funct3,
    input  logic       funct7_b5,
    input  logic       imm_form,
    output alu_op_e    op
);
    always_comb begin
        unique case (funct3)
            F3_ADDSUB: op = (funct7_b5 && !imm_form) ? OP_SUB : OP_ADD;
            F3_SLL:    op = OP_SLL;
            F3_SLT:    op = OP_SLT;
            F3_SLTU:   op = OP_SLTU;
            F3_XOR:    op = OP_XOR;
            F3_SHR:    op = funct7_b5 ? OP_SRA : OP_SRL;
            F3_OR:     op = OP_OR;
            default:   op = OP_AND;
        endcase
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int unsigned XLEN = 32,
    localparam int unsigned SHW = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] din,
    input  logic [SHW-1:0]  amount,
    input  logic            go_left,
    input  logic            arith,
    output logic [XLEN-1:0] dout
);
    logic [XLEN-1:0] rev_in;
    logic [XLEN-1:0] stage [SHW+1];
    logic            fill;

    always_comb begin
        for (int i = 0; i < XLEN; i++) rev_in[i] = din[XLEN-1-i];
    end

    assign fill     = arith & din[XLEN-1];
    assign stage[0] = go_left ? rev_in : din;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int unsigned STEP = 1 << s;
        assign stage[s+1] = amount[s]
            ? {{STEP{fill}}, stage[s][XLEN-1:STEP]}
            : stage[s];
    end

    always_comb begin
        for (int i = 0; i < XLEN; i++)
            dout[i] = go_left ? stage[SHW][XLEN-1-i] : stage[SHW][i];
    end
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            lt_signed,
    output logic            lt_unsigned
);
    logic [XLEN:0] diff;

    assign diff        = {1'b0, a} - {1'b0, b};
    assign lt_unsigned = diff[XLEN];
    assign lt_signed   = (a[XLEN-1] ^ b[XLEN-1]) ? a[XLEN-1] : diff[XLEN];
endmodule

// File: rtl/rv_int_alu.sv
module rv_int_alu
    import alu_pkg::*;
#(
    parameter int unsigned XLEN = ALU_XLEN,
    localparam int unsigned SHW = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic [2:0]      funct3,
    input  logic            funct7_b5,
    input  logic            imm_form,
    output logic [XLEN-1:0] result
);
    typedef struct packed {
        logic [XLEN-1:0] res;
    } alu_state_t;

    alu_state_t      state_d, state_q;
    alu_op_e         op;
    logic [XLEN-1:0] shift_out;
    logic            lt_s, lt_u;

    alu_decode u_decode (
        .funct3    (funct3),
        .funct7_b5 (funct7_b5),
        .imm_form  (imm_form),
        .op        (op)
    );

    alu_shifter #(.XLEN(XLEN)) u_shift (
        .din     (opnd_a),
        .amount  (opnd_b[SHW-1:0]),
        .go_left (op == OP_SLL),
        .arith   (op == OP_SRA),
        .dout    (shift_out)
    );

    alu_compare #(.XLEN(XLEN)) u_cmp (
        .a           (opnd_a),
        .b           (opnd_b),
        .lt_signed   (lt_s),
        .lt_unsigned (lt_u)
    );

    always_comb begin
        state_d = state_q;
        unique case (op)
            OP_ADD:  state_d.res = opnd_a + opnd_b;
            OP_SUB:  state_d.res = opnd_a - opnd_b;
            OP_SLT:  state_d.res = {{(XLEN-1){1'b0}}, lt_s};
            OP_SLTU: state_d.res = {{(XLEN-1){1'b0}}, lt_u};
            OP_XOR:  state_d.res = opnd_a ^ opnd_b;
            OP_OR:   state_d.res = opnd_a | opnd_b;
            OP_AND:  state_d.res = opnd_a & opnd_b;
            default: state_d.res = shift_out;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign result = state_q.res;
endmodule

// File: rtl/alu_chk.sv
module alu_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] opnd_a,
    input logic [XLEN-1:0] opnd_b,
    input logic [2:0]      funct3,
    input logic            funct7_b5,
    input logic            imm_form,
    input logic [XLEN-1:0] result
);
    always @(negedge clk) begin
        if (!rst_n) AST_RESET_ZERO: assert (result == '0); // R8
    end

    AST_IMM_ALWAYS_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_form && funct3 == 3'b000) |=> result == $past(opnd_a) + $past(opnd_b)); // R2

    AST_SLT_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (funct3 == 3'b010) |=> result[XLEN-1:1] == '0); // R3

    AST_SLTU_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (funct3 == 3'b011) |=> result[XLEN-1:1] == '0); // R4

    AST_AND_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (funct3 == 3'b111) |=> (result & ~$past(opnd_a)) == '0); // R5

    AST_OR_SUPERSET: assert property (@(posedge clk) disable iff (!rst_n)
        (funct3 == 3'b110) |=> (result & $past(opnd_a)) == $past(opnd_a)); // R5

    AST_SLL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (funct3 == 3'b001 && opnd_b[0]) |=> result[0] == 1'b0); // R6

    AST_SRA_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (funct3 == 3'b101 && funct7_b5) |=> result[XLEN-1] == $past(opnd_a[XLEN-1])); // R7

    AST_SRL_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (funct3 == 3'b101 && !funct7_b5 && opnd_b[4:0] != 5'd0) |=> result[XLEN-1] == 1'b0); // R7
endmodule

bind rv_int_alu alu_chk #(.XLEN(XLEN)) u_alu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .funct3    (funct3),
    .funct7_b5 (funct7_b5),
    .imm_form  (imm_form),
    .result    (result)
);

// File: tb/rv_int_alu_bench.sv
module rv_int_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [2:0]  funct3 = '0;
    logic        funct7_b5 = 1'b0;
    logic        imm_form = 1'b0;
    logic [31:0] result;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #2 clk = ~clk;

    rv_int_alu u_rv_int_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .funct3    (funct3),
        .funct7_b5 (funct7_b5),
        .imm_form  (imm_form),
        .result    (result)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] f3, input logic f7, input logic imm,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] exp, input string tag);
        sb_item_t it;
        @(negedge clk);
        funct3 = f3; funct7_b5 = f7; imm_form = imm; opnd_a = a; opnd_b = b;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            check(it.tag, result, it.exp);
        end
    end

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                check("R8 reset", result, 32'h0);
                rst_n = 1'b1;
                drive(3'b000, 1'b0, 1'b0, 32'd5,        32'd7,        32'd12,       "R1 add");
                drive(3'b000, 1'b0, 1'b0, 32'hFFFFFFFF, 32'd1,        32'h0,        "R1 add wrap");
                drive(3'b000, 1'b1, 1'b0, 32'd3,        32'd5,        32'hFFFFFFFE, "R1 sub");
                drive(3'b000, 1'b1, 1'b0, 32'h80000000, 32'd1,        32'h7FFFFFFF, "R1 sub wrap");
                drive(3'b000, 1'b1, 1'b1, 32'd10,       32'd3,        32'd13,       "R2 imm add bit30");
                drive(3'b010, 1'b0, 1'b0, 32'hFFFFFFFF, 32'd1,        32'd1,        "R3 slt neg<pos");
                drive(3'b010, 1'b0, 1'b1, 32'd1,        32'hFFFFFFFF, 32'd0,        "R3 slt pos<neg");
                drive(3'b011, 1'b0, 1'b0, 32'hFFFFFFFF, 32'd1,        32'd0,        "R4 sltu big<1");
                drive(3'b011, 1'b0, 1'b1, 32'd1,        32'hFFFFFFFF, 32'd1,        "R4 sltu 1<big");
                drive(3'b100, 1'b0, 1'b1, 32'h12345678, 32'hFFFFFFFF, 32'hEDCBA987, "R5 xor invert");
                drive(3'b110, 1'b0, 1'b0, 32'hF0F00000, 32'h0000FF0F, 32'hF0F0FF0F, "R5 or");
                drive(3'b111, 1'b0, 1'b0, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, "R5 and");
                drive(3'b001, 1'b0, 1'b0, 32'd1,        32'h00000024, 32'h00000010, "R6 sll masked amount");
                drive(3'b001, 1'b0, 1'b1, 32'h80000001, 32'h0000001F, 32'h80000000, "R6 sll 31");
                drive(3'b101, 1'b0, 1'b0, 32'h80000000, 32'd4,        32'h08000000, "R7 srl");
                drive(3'b101, 1'b1, 1'b0, 32'h80000000, 32'd4,        32'hF8000000, "R7 sra neg");
                drive(3'b101, 1'b1, 1'b1, 32'h80000010, 32'h00000404, 32'hF8000001, "R7 srai neg");
                drive(3'b101, 1'b1, 1'b0, 32'h7FFFFFF0, 32'd4,        32'h07FFFFFF, "R7 sra pos");
                repeat (4) @(negedge clk);
                check("R8 queue drained", 32'(sb_q.size()), 32'd0);
            end
            begin
                repeat (2000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule